// File: doc/BRIEF.md
# Cache Control Register Unit

This block holds the software-visible control state for a processor's instruction and data caches. A 32-bit register port exposes one writable control word and two constant configuration words. Each access carries an address, a write enable, and a size given in bytes. The block returns read data combinationally from its current state. It also drives the present state of each cache as a 2-bit output, which the cache logic elsewhere on the chip consumes.

Each cache has a 2-bit state field:

| Code | State |
|------|-------|
| 00 | disabled |
| 01 | frozen |
| 11 | enabled |

Each cache also has its own freeze-on-interrupt enable. A single-cycle interrupt-taken pulse moves an enabled cache to frozen when that cache's enable is set, without any write from software.

When a control write carries flush commands, the block accepts them but does not keep them. The block also never keeps the pending flags or the burst-fetch bit. These bits always read back as zero.

Top module: `cache_ctl_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control word is cleared. Afterwards it reads 0 at offset 0x0, and both state outputs are 00 (disabled).
- R2: A 32-bit write (`reg_size`=4) to offset 0x0 stores the data at the next rising edge. All bits outside the cleared set of R3 are kept, including bit 23. They read back unchanged at offset 0x0 with `reg_size`=4.
- R3: Control bits 14, 15, 16, 21 and 22 are forced to zero on every write and always read back as zero.
- R4: `icache_state` equals control bits [1:0] and `dcache_state` equals control bits [3:2]. The code 00 means disabled, 01 frozen and 11 enabled.
- R5: A 32-bit read at offset 0x4 returns 32'h10220000, and a 32-bit read at offset 0x8 returns 32'h18220000. Writes to either offset leave the control word unchanged.
- R6: Any access with `reg_size` other than 4 reads as zero, and a write of such an access leaves the control word unchanged.
- R7: Any offset other than 0x0, 0x4 or 0x8 reads as zero, and a write there leaves the control word unchanged.
- R8: When `irq_taken` is high at a rising edge and control bit 4 is 1, an instruction state of 11 becomes 01. Any other instruction state is kept.
- R9: When `irq_taken` is high at a rising edge and control bit 5 is 1, a data state of 11 becomes 01. Any other data state is kept.
- R10: When `irq_taken` is high and the freeze bit of a cache is 0, that cache's state does not change.
- R11: If a valid control write and `irq_taken` occur in the same cycle, the written value is taken first. The freeze rules of R8 and R9 are then applied to it, using the freeze bits just written.
- R12: Reads reflect the current register value combinationally. A write becomes visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_size | input | SIZE_W (4) | Access size in bytes; only 4 is honoured |
| reg_wr_en | input | 1 | Write strobe for the current access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_taken | input | 1 | One-cycle pulse marking an interrupt taken |
| icache_state | output | 2 | Instruction cache state (00 off, 01 frozen, 11 on) |
| dcache_state | output | 2 | Data cache state (00 off, 01 frozen, 11 on) |

## Verification
The bench sweeps every offset against every size code, for both reads and writes. This catches a decoder that ignores the size or that aliases offsets by decoding too few address bits: such a design would return configuration data, or change the control word, from an unmapped or short access.

For the freeze behaviour, the bench tries all sixteen pairs of state values under all four combinations of freeze enables. It does this both with an interrupt alone and with an interrupt that coincides with a write. A design that froze the disabled code or the unused 10 code, or that checked the freeze bits before applying the written value, would show a wrong state in one of those combinations.

Separate cases probe the read value before and after the write edge, and a bit-23 write. These expose reads that are registered, and over-broad clearing masks.

// File: rtl/ccr_pkg.sv
// Package: shared encodings and layout constants for the cache control
// register unit. Assumes a 32-bit register word and two caches.
package ccr_pkg;

    // Cache state codes held in each 2-bit state field.
    typedef enum logic [1:0] {
        CST_OFF    = 2'b00,
        CST_FROZEN = 2'b01,
        CST_RSVD   = 2'b10,
        CST_ON     = 2'b11
    } cache_state_e;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned WORD_BYTES  = 4;
    localparam int unsigned NUM_CACHES  = 2;
    localparam int unsigned STATE_W     = 2;
    // Freeze-enable bits sit just above the packed state fields.
    localparam int unsigned FRZ_BASE    = NUM_CACHES * STATE_W;

    // Byte offsets of the three registers.
    localparam int unsigned OFF_CTRL    = 32'h0;
    localparam int unsigned OFF_ICFG    = 32'h4;
    localparam int unsigned OFF_DCFG    = 32'h8;

    // Bits dropped on every control write: 14, 15, 16, 21, 22.
    localparam logic [REG_W-1:0] WR_CLEAR_MASK = 32'h0061_C000;

endpackage

// File: rtl/ccr_decode.sv
// Module: ccr_decode
// Turns an access (offset, size, write strobe) into one-hot register
// selects. Assumes only full-word accesses are honoured; any other size
// selects nothing.
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              wr_en,
    output logic              sel_ctrl,
    output logic              sel_icfg,
    output logic              sel_dcfg,
    output logic              wr_ctrl
);

    localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_ICFG    = ADDR_W'(OFF_ICFG);
    localparam logic [ADDR_W-1:0] A_DCFG    = ADDR_W'(OFF_DCFG);

    logic word_ok;

    // Qualify the access size and match the offset against each register.
    always_comb begin
        word_ok  = (size == FULL_SIZE);
        sel_ctrl = word_ok && (addr == A_CTRL);
        sel_icfg = word_ok && (addr == A_ICFG);
        sel_dcfg = word_ok && (addr == A_DCFG);
        wr_ctrl  = wr_en && sel_ctrl;
    end

endmodule

// File: rtl/ccr_freeze_field.sv
// Module: ccr_freeze_field
// Next-state rule for one cache state field on an interrupt: enabled
// becomes frozen when the field's freeze enable is set; every other code
// passes through. Purely combinational.
module ccr_freeze_field
    import ccr_pkg::*;
(
    input  logic [STATE_W-1:0] cur,
    input  logic               arm,
    input  logic               irq,
    output logic [STATE_W-1:0] nxt
);

    // Apply the freeze transition only to the enabled code.
    always_comb begin
        if (irq && arm && (cur == CST_ON)) begin
            nxt = CST_FROZEN;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/ccr_ctrl_reg.sv
// Module: ccr_ctrl_reg
// Holds the control word. A write is masked and staged first; the
// per-cache freeze rule then runs on the staged value, so a write and an
// interrupt in one cycle compose in that order. Synchronous active-low reset.
module ccr_ctrl_reg
    import ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [REG_W-1:0] wdata,
    input  logic             irq,
    output logic [REG_W-1:0] ctrl_q
);

    localparam int unsigned FIELDS_W = NUM_CACHES * STATE_W;

    logic [REG_W-1:0]    staged;
    logic [FIELDS_W-1:0] frozen;
    logic [REG_W-1:0]    ctrl_d;

    // Stage the software write with the non-stored bits removed.
    always_comb begin
        staged = wr_ctrl ? (wdata & ~WR_CLEAR_MASK) : ctrl_q;
    end

    // One freeze rule per cache, each armed by its own enable bit.
    for (genvar g = 0; g < NUM_CACHES; g++) begin : g_frz
        ccr_freeze_field u_frz (
            .cur (staged[g*STATE_W +: STATE_W]),
            .arm (staged[FRZ_BASE + g]),
            .irq (irq),
            .nxt (frozen[g*STATE_W +: STATE_W])
        );
    end

    // Merge frozen state fields back into the staged word.
    always_comb begin
        ctrl_d                 = staged;
        ctrl_d[FIELDS_W-1:0]   = frozen;
    end

    // Register the control word; reset disables both caches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/ccr_read_mux.sv
// Module: ccr_read_mux
// Selects read data from the one-hot selects. Unselected accesses read
// zero. Assumes the selects are mutually exclusive.
module ccr_read_mux
    import ccr_pkg::*;
#(
    parameter logic [REG_W-1:0] ICFG_VAL = 32'h1022_0000,
    parameter logic [REG_W-1:0] DCFG_VAL = 32'h1822_0000
) (
    input  logic             sel_ctrl,
    input  logic             sel_icfg,
    input  logic             sel_dcfg,
    input  logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] rdata
);

    // Return the selected register, or zero for no match.
    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata = ctrl_q;
        end else if (sel_icfg) begin
            rdata = ICFG_VAL;
        end else if (sel_dcfg) begin
            rdata = DCFG_VAL;
        end
    end

endmodule

// File: rtl/cache_ctl_regs.sv
// Module: cache_ctl_regs (top)
// Cache control register unit: one writable control word, two constant
// configuration words, freeze-on-interrupt for the two cache state fields.
// Assumes reg_size counts bytes and reads need no strobe.
module cache_ctl_regs
    import ccr_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter int unsigned      SIZE_W   = 4,
    parameter logic [REG_W-1:0] ICFG_VAL = 32'h1022_0000,
    parameter logic [REG_W-1:0] DCFG_VAL = 32'h1822_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SIZE_W-1:0] reg_size,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              irq_taken,
    output logic [1:0]        icache_state,
    output logic [1:0]        dcache_state
);

    logic             sel_ctrl;
    logic             sel_icfg;
    logic             sel_dcfg;
    logic             wr_ctrl;
    logic [REG_W-1:0] ctrl_q;

    ccr_decode #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_dec (
        .addr     (reg_addr),
        .size     (reg_size),
        .wr_en    (reg_wr_en),
        .sel_ctrl (sel_ctrl),
        .sel_icfg (sel_icfg),
        .sel_dcfg (sel_dcfg),
        .wr_ctrl  (wr_ctrl)
    );

    ccr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wdata   (reg_wdata),
        .irq     (irq_taken),
        .ctrl_q  (ctrl_q)
    );

    ccr_read_mux #(
        .ICFG_VAL (ICFG_VAL),
        .DCFG_VAL (DCFG_VAL)
    ) u_rmux (
        .sel_ctrl (sel_ctrl),
        .sel_icfg (sel_icfg),
        .sel_dcfg (sel_dcfg),
        .ctrl_q   (ctrl_q),
        .rdata    (reg_rdata)
    );

    // Export the two state fields to the cache logic.
    always_comb begin
        icache_state = ctrl_q[0 +: STATE_W];
        dcache_state = ctrl_q[STATE_W +: STATE_W];
    end

endmodule

// File: rtl/ccr_checker.sv
// Module: ccr_checker
// Property checks for cache_ctl_regs, attached by bind below. Observes the
// ports and the registered control word.
module ccr_checker
    import ccr_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 8,
    parameter int unsigned      SIZE_W   = 4,
    parameter logic [REG_W-1:0] ICFG_VAL = 32'h1022_0000,
    parameter logic [REG_W-1:0] DCFG_VAL = 32'h1822_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [SIZE_W-1:0] reg_size,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_taken,
    input logic [1:0]        icache_state,
    input logic [1:0]        dcache_state,
    input logic [REG_W-1:0]  ctrl_q
);

    localparam logic [SIZE_W-1:0] FULL = SIZE_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] A_C  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_I  = ADDR_W'(OFF_ICFG);
    localparam logic [ADDR_W-1:0] A_D  = ADDR_W'(OFF_DCFG);

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_C && reg_size == FULL && !irq_taken)
        |=> (ctrl_q == ($past(reg_wdata) & ~WR_CLEAR_MASK))); // R2

    AST_CLEARED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q & WR_CLEAR_MASK) == '0)); // R3

    AST_ICFG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_size == FULL && reg_addr == A_I) |-> (reg_rdata == ICFG_VAL)); // R5

    AST_DCFG_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_size == FULL && reg_addr == A_D) |-> (reg_rdata == DCFG_VAL)); // R5

    AST_SHORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_size != FULL) |-> (reg_rdata == '0)); // R6

    AST_STRAY_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !(reg_addr == A_C && reg_size == FULL) && !irq_taken)
        |=> $stable(ctrl_q)); // R7

    AST_IFREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !reg_wr_en && ctrl_q[FRZ_BASE] && icache_state == 2'b11)
        |=> (icache_state == 2'b01)); // R8

    AST_DFREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !reg_wr_en && ctrl_q[FRZ_BASE+1] && dcache_state == 2'b11)
        |=> (dcache_state == 2'b01)); // R9

    AST_NO_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !reg_wr_en && !ctrl_q[FRZ_BASE])
        |=> $stable(icache_state)); // R10

endmodule

bind cache_ctl_regs ccr_checker #(
    .ADDR_W   (ADDR_W),
    .SIZE_W   (SIZE_W),
    .ICFG_VAL (ICFG_VAL),
    .DCFG_VAL (DCFG_VAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_size     (reg_size),
    .reg_wr_en    (reg_wr_en),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_taken    (irq_taken),
    .icache_state (icache_state),
    .dcache_state (dcache_state),
    .ctrl_q       (ctrl_q)
);

// File: tb/tb_cache_ctl_regs.sv
`timescale 1ns/1ps
// Bench for cache_ctl_regs: sweeps offsets, sizes and freeze combinations,
// computing every expected value from the requirements.
module tb_cache_ctl_regs;

    localparam logic [31:0] CLR  = 32'h0061_C000;
    localparam logic [31:0] ICFG = 32'h1022_0000;
    localparam logic [31:0] DCFG = 32'h1822_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  reg_addr;
    logic [3:0]  reg_size;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_taken;
    logic [1:0]  icache_state;
    logic [1:0]  dcache_state;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    cache_ctl_regs dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_size     (reg_size),
        .reg_wr_en    (reg_wr_en),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_taken    (irq_taken),
        .icache_state (icache_state),
        .dcache_state (dcache_state)
    );

    // Compare and count one check.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One clock cycle with the given access and interrupt.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [3:0] s,
                       input logic [31:0] d, input logic irq_v);
        @(negedge clk);
        reg_wr_en = we; reg_addr = a; reg_size = s; reg_wdata = d; irq_taken = irq_v;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; irq_taken = 1'b0;
    endtask

    // Combinational read away from the edge.
    task automatic rd(input logic [7:0] a, input logic [3:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b0; irq_taken = 1'b0; reg_addr = a; reg_size = s;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        logic [31:0] ctrl_exp;
        logic [31:0] exp;
        string       req;

        rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_size = 4'd4;
        reg_wdata = '0; irq_taken = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        rd(8'h0, 4'd4, v);
        chk("R1", v, 32'h0);
        chk("R1", {30'b0, icache_state}, 32'h0);
        chk("R1", {30'b0, dcache_state}, 32'h0);

        // R2/R3/R4: pattern and walking-one writes
        for (int i = 0; i < 36; i++) begin
            case (i)
                32: pat = 32'hFFFF_FFFF;
                33: pat = 32'h0080_0000;
                34: pat = 32'hA5A5_A5A5;
                35: pat = 32'h5A5A_5A5A;
                default: pat = 32'h1 << i;
            endcase
            cyc(1'b1, 8'h0, 4'd4, pat, 1'b0);
            rd(8'h0, 4'd4, v);
            chk("R2", v, pat & ~CLR);
            chk("R3", v & CLR, 32'h0);
            chk("R4", {28'b0, dcache_state, icache_state}, {28'b0, pat[3:0]});
        end

        // R12: old value before the edge, new value after it
        cyc(1'b1, 8'h0, 4'd4, 32'h0000_0033, 1'b0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h0; reg_size = 4'd4; reg_wdata = 32'h0080_000C;
        #1;
        chk("R12", reg_rdata, 32'h0000_0033);
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0;
        chk("R12", reg_rdata, 32'h0080_000C);

        // R5/R6/R7: full read sweep
        ctrl_exp = 32'h1234_5678 & ~CLR;
        cyc(1'b1, 8'h0, 4'd4, 32'h1234_5678, 1'b0);
        for (int a = 0; a < 256; a++) begin
            for (int s = 0; s < 16; s++) begin
                rd(a[7:0], s[3:0], v);
                if (s != 4) begin exp = 32'h0; req = "R6"; end
                else if (a == 0) begin exp = ctrl_exp; req = "R2"; end
                else if (a == 4) begin exp = ICFG; req = "R5"; end
                else if (a == 8) begin exp = DCFG; req = "R5"; end
                else begin exp = 32'h0; req = "R7"; end
                chk(req, v, exp);
            end
        end

        // R5/R6/R7: write sweep must leave the control word alone
        for (int a = 0; a < 256; a++) begin
            for (int s = 0; s < 16; s++) begin
                if (!(a == 0 && s == 4)) begin
                    cyc(1'b1, a[7:0], s[3:0], 32'hFFFF_FFFF ^ ctrl_exp, 1'b0);
                    rd(8'h0, 4'd4, v);
                    if (s != 4) req = "R6";
                    else if (a == 4 || a == 8) req = "R5";
                    else req = "R7";
                    chk(req, v, ctrl_exp);
                end
            end
        end

        // R8/R9/R10/R11: freeze sweep
        for (int mode = 0; mode < 2; mode++) begin
            for (int iv = 0; iv < 4; iv++) begin
                for (int dv = 0; dv < 4; dv++) begin
                    for (int fe = 0; fe < 4; fe++) begin
                        logic [1:0] ei;
                        logic [1:0] ed;
                        pat = 32'h0080_0000 | (fe << 4) | (dv << 2) | iv;
                        if (mode == 0) begin
                            cyc(1'b1, 8'h0, 4'd4, pat, 1'b0);
                            cyc(1'b0, 8'h0, 4'd4, 32'h0, 1'b1);
                        end else begin
                            cyc(1'b1, 8'h0, 4'd4, 32'h0, 1'b0);
                            cyc(1'b1, 8'h0, 4'd4, pat, 1'b1);
                        end
                        ei = (fe[0] && iv == 3) ? 2'b01 : 2'(iv);
                        ed = (fe[1] && dv == 3) ? 2'b01 : 2'(dv);
                        rd(8'h0, 4'd4, v);
                        req = (mode == 1) ? "R11" : (fe[0] ? "R8" : "R10");
                        chk(req, {30'b0, icache_state}, {30'b0, ei});
                        req = (mode == 1) ? "R11" : (fe[1] ? "R9" : "R10");
                        chk(req, {30'b0, dcache_state}, {30'b0, ed});
                        chk("R4", v, {pat[31:4], ed, ei});
                    end
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule